// File: doc/BRIEF.md
# Five-level carrier-band PWM modulator

This block produces the switching pattern for one phase leg of a five-level converter. A single up/down ramp counter is turned into four triangular carriers of equal height and period. Each carrier owns its own slice of the output range, and the four slices stack without gaps from the lowest level to the highest. A signed reference sample is offset to the middle of that stack and compared against all four carriers on every clock. The block returns one comparator bit per carrier and the number of carriers that lie below the reference. That number is the level the leg should present, from 0 (negative rail) to 4 (positive rail).

The phase relation between the bands can be chosen at run time. In the first mode every band rises and falls together. In the second mode the bands below the midpoint run mirrored against the bands above it. In the third mode each band is mirrored against its neighbours. The second mode is the reset default, because with an odd level count and an even carrier-to-fundamental ratio (for example 24) it gives the lowest distortion. The amplitude modulation index is the reference peak-to-peak swing divided by four carrier heights. The frequency ratio is the carrier frequency over the reference frequency.

New reference samples arrive on a valid/ready pair. A new sample and a mode change are applied only when the ramp sits at a peak or a valley, so no pulse is ever cut mid-period. A reference that leaves the carrier stack saturates the level and raises a sticky overmodulation flag.

Top module: `band_pwm_mod`

## Requirements
- R1: While `rst` is high, on each clock the ramp returns to its valley (count 0, rising), the active reference becomes 0 and the active mode becomes 1. On the clock after a reset cycle, `level` reads 2 (half the carrier count), `cmp_bits` reads 4'b0011 (lower half set), `ovm_flag` reads 0 and `ref_ready` reads 1.
- R2: The shared ramp counts 0,1,...,CAR_TOP,CAR_TOP-1,...,1,0 and repeats, so the carrier period is 2*CAR_TOP clocks (32 by default).
- R3: Carrier k (k = 0 lowest) equals k*CAR_TOP + r, or k*CAR_TOP + (CAR_TOP - r) when band k is mirrored, where r is the ramp value. Bit k of `cmp_bits` is 1 when that carrier is strictly less than the active reference + HALF, with HALF = 2*CAR_TOP. The outputs are registered, so they show the ramp, reference and mode of the previous clock.
- R4: `disp_sel` encoding: 0 = no band mirrored; 1 = bands k < 2 mirrored; 2 = odd bands mirrored; 3 = same as 1.
- R5: `level` equals the number of ones in `cmp_bits`. It is never above 4, and `cmp_bits` is always a thermometer code filled from bit 0.
- R6: `ref_ready` is 1 exactly when no accepted sample is waiting. A sample is accepted on a clock with `ref_valid` and `ref_ready` both high, and `ref_ready` is 0 on the next clock.
- R7: The active reference and the active mode change only on a clock whose ramp value is 0 or CAR_TOP. At such a clock a waiting sample becomes active and `disp_sel` is captured.
- R8: An active reference above +HALF holds `level` at 4 for the whole period. One below -HALF holds it at 0.
- R9: `ovm_flag` is set on the clock after the active reference lies outside [-HALF, +HALF]. It stays set until a clock with `ovm_clr` high, and setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Reference sample offered |
| ref_data | input | REF_W | Signed reference sample |
| ref_ready | output | 1 | No sample waiting, a new one can be taken |
| disp_sel | input | 2 | Carrier phase arrangement, captured at peaks and valleys |
| ovm_clr | input | 1 | Clears the overmodulation flag |
| cmp_bits | output | LEVELS-1 | Per-carrier result, 1 when the carrier is below the reference |
| level | output | $clog2(LEVELS) | Output level index, 0 to LEVELS-1 |
| ovm_flag | output | 1 | Sticky overmodulation indication |

## Verification
A ramp that steps wrongly or turns one count early moves every band edge. The comparator bits then differ from the bench model within a single period of 2*CAR_TOP clocks, and the level period measured at the ports is no longer 32. A mirroring or mode-capture fault shows up within one period as a wrong thermometer count in the chosen mode. A reference that takes effect outside a peak or valley shows up in the cycle after the misplaced transfer, as a band bit that flips early. A staging fault that drops or repeats samples shows on `ref_ready` on the clock after the handshake.

// File: rtl/band_pwm_pkg.sv
package band_pwm_pkg;

  typedef enum logic [1:0] {
    DISP_SAME  = 2'd0,
    DISP_SPLIT = 2'd1,
    DISP_ALT   = 2'd2,
    DISP_SPARE = 2'd3
  } disp_e;

  // True when band 'band' runs mirrored in arrangement 'mode'.
  function automatic logic band_inverted(input disp_e mode, input int band, input int nbands);
    logic inv;
    case (mode)
      DISP_SAME: inv = 1'b0;
      DISP_ALT:  inv = (band % 2) == 1;
      default:   inv = band < (nbands / 2);
    endcase
    return inv;
  endfunction

  // Instantaneous carrier height of one band.
  function automatic int carrier_value(input int band, input int top, input int ramp_v,
                                       input logic inv);
    return band * top + (inv ? (top - ramp_v) : ramp_v);
  endfunction

  // Reference lies outside the stacked carrier range.
  function automatic logic beyond_span(input int ref_v, input int half);
    return (ref_v > half) || (ref_v < -half);
  endfunction

endpackage

// File: rtl/band_pwm_ramp.sv
module band_pwm_ramp #(
  parameter int TOP = 16,
  parameter int TW  = 5
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] ramp,
  output logic          at_valley,
  output logic          at_peak
);
  logic [TW-1:0] ramp_q;
  logic          rising_q;

  assign ramp      = ramp_q;
  assign at_valley = ramp_q == '0;
  assign at_peak   = ramp_q == TW'(TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp_q   <= '0;
      rising_q <= 1'b1;
    end else if (at_peak) begin
      ramp_q   <= ramp_q - 1'b1;
      rising_q <= 1'b0;
    end else if (at_valley) begin
      ramp_q   <= ramp_q + 1'b1;
      rising_q <= 1'b1;
    end else if (rising_q) begin
      ramp_q <= ramp_q + 1'b1;
    end else begin
      ramp_q <= ramp_q - 1'b1;
    end
  end
endmodule

// File: rtl/band_pwm_stage.sv
module band_pwm_stage
  import band_pwm_pkg::*;
#(
  parameter int    REF_W    = 8,
  parameter disp_e RST_MODE = DISP_SPLIT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    boundary,
  input  logic                    ref_valid,
  input  logic [REF_W-1:0]        ref_data,
  input  disp_e                   mode_in,
  output logic                    ref_ready,
  output logic signed [REF_W-1:0] act_ref,
  output disp_e                   act_mode
);
  logic [REF_W-1:0] pend_q;
  logic             full_q;
  logic             take_sample;
  logic             apply_sample;

  assign ref_ready    = !full_q;
  assign take_sample  = ref_valid && !full_q;
  assign apply_sample = boundary && full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      full_q   <= 1'b0;
      act_ref  <= '0;
      act_mode <= RST_MODE;
    end else begin
      if (apply_sample) begin
        act_ref <= $signed(pend_q);
        full_q  <= 1'b0;
      end
      if (take_sample) begin
        pend_q <= ref_data;
        full_q <= 1'b1;
      end
      if (boundary) act_mode <= mode_in;
    end
  end
endmodule

// File: rtl/band_pwm_bank.sv
module band_pwm_bank
  import band_pwm_pkg::*;
#(
  parameter int NC  = 4,
  parameter int TOP = 16,
  parameter int TW  = 5,
  parameter int CW  = 7,
  parameter int OW  = 10
) (
  input  logic [TW-1:0]        ramp,
  input  disp_e                mode,
  input  logic signed [OW-1:0] ref_off,
  output logic [NC-1:0]        below
);
  for (genvar k = 0; k < NC; k++) begin : g_band
    logic          inv;
    int            cval;
    logic [CW-1:0] carrier;
    always_comb begin
      inv  = band_inverted(mode, k, NC);
      cval = carrier_value(k, TOP, int'(ramp), inv);
    end
    assign carrier  = CW'(cval);
    assign below[k] = $signed({{(OW-CW){1'b0}}, carrier}) < ref_off;
  end
endmodule

// File: rtl/band_pwm_level.sv
module band_pwm_level
  import band_pwm_pkg::*;
#(
  parameter int NC    = 4,
  parameter int LW    = 3,
  parameter int REF_W = 8,
  parameter int HALF  = 32
) (
  input  logic [NC-1:0]           below,
  input  logic signed [REF_W-1:0] act_ref,
  output logic [LW-1:0]           level_next,
  output logic                    over_range
);
  int ones;
  always_comb begin
    ones = 0;
    for (int k = 0; k < NC; k++) ones = ones + int'(below[k]);
    level_next = LW'(ones);
    over_range = beyond_span(int'(act_ref), HALF);
  end
endmodule

// File: rtl/band_pwm_mod.sv
module band_pwm_mod
  import band_pwm_pkg::*;
#(
  parameter int  LEVELS  = 5,
  parameter int  CAR_TOP = 16,
  parameter int  REF_W   = 8,
  localparam int NC      = LEVELS - 1,
  localparam int LW      = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [REF_W-1:0] ref_data,
  output logic             ref_ready,
  input  logic [1:0]       disp_sel,
  input  logic             ovm_clr,
  output logic [NC-1:0]    cmp_bits,
  output logic [LW-1:0]    level,
  output logic             ovm_flag
);
  localparam int TW   = $clog2(CAR_TOP + 1);
  localparam int SPAN = NC * CAR_TOP;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int HALF = SPAN / 2;
  localparam int OW   = ((REF_W > CW) ? REF_W : CW) + 2;
  localparam logic [NC-1:0] RST_CMP = NC'((1 << (NC / 2)) - 1);
  localparam logic [LW-1:0] RST_LVL = LW'(NC / 2);

  logic [TW-1:0]           ramp;
  logic                    at_valley;
  logic                    at_peak;
  logic                    boundary;
  disp_e                   mode_in;
  logic signed [REF_W-1:0] act_ref;
  disp_e                   act_mode;
  logic signed [OW-1:0]    ref_off;
  logic [NC-1:0]           below;
  logic [LW-1:0]           level_next;
  logic                    over_range;

  assign boundary = at_valley || at_peak;
  assign mode_in  = disp_e'(disp_sel);
  assign ref_off  = OW'(act_ref) + OW'(HALF);

  band_pwm_ramp #(.TOP(CAR_TOP), .TW(TW)) u_ramp (
    .clk(clk), .rst(rst), .ramp(ramp), .at_valley(at_valley), .at_peak(at_peak)
  );

  band_pwm_stage #(.REF_W(REF_W), .RST_MODE(DISP_SPLIT)) u_stage (
    .clk(clk), .rst(rst), .boundary(boundary), .ref_valid(ref_valid),
    .ref_data(ref_data), .mode_in(mode_in), .ref_ready(ref_ready),
    .act_ref(act_ref), .act_mode(act_mode)
  );

  band_pwm_bank #(.NC(NC), .TOP(CAR_TOP), .TW(TW), .CW(CW), .OW(OW)) u_bank (
    .ramp(ramp), .mode(act_mode), .ref_off(ref_off), .below(below)
  );

  band_pwm_level #(.NC(NC), .LW(LW), .REF_W(REF_W), .HALF(HALF)) u_level (
    .below(below), .act_ref(act_ref), .level_next(level_next), .over_range(over_range)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_bits <= RST_CMP;
      level    <= RST_LVL;
      ovm_flag <= 1'b0;
    end else begin
      cmp_bits <= below;
      level    <= level_next;
      ovm_flag <= over_range || (ovm_flag && !ovm_clr);
    end
  end
endmodule

// File: rtl/band_pwm_chk.sv
module band_pwm_chk
  import band_pwm_pkg::*;
#(
  parameter int NC    = 4,
  parameter int LW    = 3,
  parameter int TW    = 5,
  parameter int TOP   = 16,
  parameter int REF_W = 8,
  parameter int HALF  = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NC-1:0]           cmp_bits,
  input logic [LW-1:0]           level,
  input logic                    ovm_flag,
  input logic                    ovm_clr,
  input logic                    ref_valid,
  input logic                    ref_ready,
  input logic [TW-1:0]           ramp,
  input logic                    at_peak,
  input logic                    at_bound,
  input logic signed [REF_W-1:0] act_ref,
  input disp_e                   act_mode
);
  assert_reset_mid_R1: assert property (@(posedge clk)
    rst |=> (level == LW'(NC / 2)) && (ramp == '0) && !ovm_flag);

  assert_peak_turn_R2: assert property (@(posedge clk) disable iff (rst)
    at_peak |=> ramp == TW'(TOP - 1));

  assert_ramp_bound_R2: assert property (@(posedge clk) disable iff (rst)
    ramp <= TW'(TOP));

  assert_thermo_R5: assert property (@(posedge clk) disable iff (rst)
    ((cmp_bits + 1'b1) & cmp_bits) == '0);

  assert_level_count_R5: assert property (@(posedge clk) disable iff (rst)
    level == LW'($countones(cmp_bits)));

  assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && ref_ready) |=> !ref_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !at_bound |=> $stable(act_ref) && $stable(act_mode));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(act_ref) > HALF) |=> level == LW'(NC));

  assert_ovm_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovm_flag && !ovm_clr) |=> ovm_flag);
endmodule

bind band_pwm_mod band_pwm_chk #(
  .NC(NC), .LW(LW), .TW(TW), .TOP(CAR_TOP), .REF_W(REF_W), .HALF(HALF)
) u_chk (
  .clk(clk), .rst(rst), .cmp_bits(cmp_bits), .level(level), .ovm_flag(ovm_flag),
  .ovm_clr(ovm_clr), .ref_valid(ref_valid), .ref_ready(ref_ready), .ramp(ramp),
  .at_peak(at_peak), .at_bound(boundary), .act_ref(act_ref), .act_mode(act_mode)
);

// File: tb/band_pwm_mod_test.sv
`timescale 1ns/1ps
module band_pwm_mod_test;
  localparam int LEVELS = 5;
  localparam int TOP    = 16;
  localparam int REF_W  = 8;
  localparam int NC     = LEVELS - 1;
  localparam int HALF   = NC * TOP / 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             ref_valid = 1'b0;
  logic [REF_W-1:0] ref_data = '0;
  logic             ref_ready;
  logic [1:0]       disp_sel = 2'd1;
  logic             ovm_clr = 1'b0;
  logic [NC-1:0]    cmp_bits;
  logic [2:0]       level;
  logic             ovm_flag;

  band_pwm_mod #(.LEVELS(LEVELS), .CAR_TOP(TOP), .REF_W(REF_W)) uut (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_data(ref_data),
    .ref_ready(ref_ready), .disp_sel(disp_sel), .ovm_clr(ovm_clr),
    .cmp_bits(cmp_bits), .level(level), .ovm_flag(ovm_flag)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int      m_ramp, m_pend, m_aref, m_amode, m_level, m_car, m_hits;
  bit      m_up, m_full, m_ovm, m_live, m_bnd;
  bit [NC-1:0] m_cmp;

  function automatic bit mirrored(input int mode, input int k);
    if (mode == 0) return 1'b0;
    if (mode == 2) return (k % 2) == 1;
    return k < NC / 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ramp = 0; m_up = 1; m_full = 0; m_pend = 0; m_aref = 0; m_amode = 1;
      m_cmp = NC'((1 << (NC / 2)) - 1); m_level = NC / 2; m_ovm = 0; m_live = 1;
    end else begin
      m_hits = 0;
      for (int k = 0; k < NC; k++) begin
        m_car = mirrored(m_amode, k) ? (k + 1) * TOP - m_ramp : k * TOP + m_ramp;
        m_cmp[k] = m_car < m_aref + HALF;
        if (m_cmp[k]) m_hits++;
      end
      m_level = m_hits;
      m_ovm = (m_aref > HALF) || (m_aref < -HALF) || (m_ovm && !ovm_clr);
      m_bnd = (m_ramp == 0) || (m_ramp == TOP);
      if (m_bnd) m_amode = int'(disp_sel);
      if (m_full) begin
        if (m_bnd) begin m_aref = m_pend; m_full = 0; end
      end else if (ref_valid) begin
        m_pend = int'($signed(ref_data)); m_full = 1;
      end
      if (m_ramp == TOP) begin m_ramp = TOP - 1; m_up = 0; end
      else if (m_ramp == 0) begin m_ramp = 1; m_up = 1; end
      else if (m_up) m_ramp++;
      else m_ramp--;
    end
  end

  always @(negedge clk) begin
    if (m_live) begin
      check("R3/R4/R7", "cmp_bits", int'(cmp_bits), int'(m_cmp));
      check("R5", "level", int'(level), m_level);
      check("R9", "ovm_flag", int'(ovm_flag), int'(m_ovm));
      check("R6", "ref_ready", int'(ref_ready), int'(!m_full));
    end
  end

  // Offer one sample; called at a falling edge, returns at a falling edge.
  task automatic send(input int v);
    ref_data  = REF_W'(v);
    ref_valid = 1'b1;
    while (!ref_ready) @(negedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
    check("R6", "ready after accept", int'(ref_ready), 0);
  endtask

  task automatic settle();
    repeat (3 * 2 * TOP) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    int period, off4, off0;
    repeat (3) @(negedge clk);
    check("R1", "reset level", int'(level), 2);
    check("R1", "reset cmp_bits", int'(cmp_bits), 3);
    check("R1", "reset ovm_flag", int'(ovm_flag), 0);
    check("R1", "reset ref_ready", int'(ref_ready), 1);
    rst = 1'b0;

    // R2: in-phase arrangement, reference 0 gives level 1 once per period
    disp_sel = 2'd0;
    settle();
    while (level != 3'd1) @(negedge clk);
    @(negedge clk);
    period = 1;
    while (level != 3'd1 && period < 200) begin @(negedge clk); period++; end
    check("R2", "carrier period", period, 2 * TOP);

    // R4/R7: sweep references in every arrangement, including the spare code
    for (int m = 0; m < 4; m++) begin
      disp_sel = 2'(m);
      for (int i = 0; i < 7; i++) begin
        send(((i * 23 + m * 11) % 65) - 32);
        repeat (5 + i * 3) @(negedge clk);
      end
    end

    // R8/R9: overdrive high then low
    disp_sel = 2'd1;
    send(100);
    settle();
    off4 = 0;
    for (int c = 0; c < 2 * TOP; c++) begin
      if (level != 3'd4) off4++;
      @(negedge clk);
    end
    check("R8", "cycles below level 4", off4, 0);
    check("R9", "flag after overdrive", int'(ovm_flag), 1);
    send(-100);
    settle();
    off0 = 0;
    for (int c = 0; c < 2 * TOP; c++) begin
      if (level != 3'd0) off0++;
      @(negedge clk);
    end
    check("R8", "cycles above level 0", off0, 0);

    // R9: clear while still overdriven, set wins
    ovm_clr = 1'b1;
    @(negedge clk);
    ovm_clr = 1'b0;
    check("R9", "flag with clear during overdrive", int'(ovm_flag), 1);
    send(0);
    settle();
    check("R9", "flag held after return", int'(ovm_flag), 1);
    ovm_clr = 1'b1;
    @(negedge clk);
    ovm_clr = 1'b0;
    check("R9", "flag cleared", int'(ovm_flag), 0);
    repeat (5) @(negedge clk);
    check("R9", "flag stays clear", int'(ovm_flag), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule